// File: doc/BRIEF.md
# Local Buffer Memory Bus Arbiter

This block is the state machine that owns the local packet-buffer memory bus of a network controller. It has four states: RESET, IDLE, MASTER and SLAVE. In MASTER it runs fixed-length bursts for one of two requesters. The first is the receive/transmit FIFO, called the local DMA. The second, used only in I/O mode, is a host-programmed remote DMA. In SLAVE it hands the bus to the host CPU for direct access, which is available only in shared-memory mode.

The block enters RESET on any of four causes: the hard reset pin, a stop command, a register-triggered reset, or a fatal error such as a FIFO underflow or overflow or a receive ring overflow. It leaves RESET only when a start command arrives. Receive and transmit stay disabled while it is in RESET.

Each burst moves the programmed number of bytes, one per cycle, and then returns the bus. Once a local burst has ended with the FIFO still requesting, the next local burst waits until the FIFO level rises above its threshold.

Top module: `lbus_arbiter`

## Requirements
- R1: While rst_n is low the block is asynchronously in RESET (state code 0), with bus_grant, host_grant and mac_en all low.
- R2: In RESET every request is ignored and the state holds until start_cmd is sampled high; the state then becomes IDLE (code 1) after one clock. In any other state start_cmd has no effect.
- R3: stop_cmd, reg_reset and fatal_err each force RESET on the next clock from any state, and each takes priority over start_cmd. bus_grant and host_grant are low in every cycle in which any of the three is high.
- R4: From IDLE, an eligible fifo_req enters MASTER (code 2) on the next clock with burst_src=0. bus_grant then stays high for exactly N cycles, after which the state returns to IDLE. N is set by burst_sel, sampled in the IDLE cycle in which the burst is granted: code 0 gives 2, code 1 gives 4, code 2 gives 8 and code 3 gives 12.
- R5: After a local burst completes, a fifo_req that stays high is eligible only while fifo_level > fifo_thresh. The gate is cleared by an IDLE cycle with fifo_req low, or by entry into RESET. The first request after start is not gated.
- R6: With io_mode=1, rdma_req in IDLE enters MASTER with burst_src=1 for N cycles, where N is coded as in R4. With io_mode=0, rdma_req is ignored.
- R7: When an eligible fifo_req and a usable rdma_req are both present in IDLE, the local burst is served first.
- R8: Once a burst has started it is never preempted. Other requests and changes to burst_sel during the burst leave its length and burst_src unchanged.
- R9: With io_mode=0 and no eligible fifo_req, host_req in IDLE enters SLAVE (code 3) on the next clock. host_grant stays high while host_req stays high, and the state returns to IDLE one clock after host_req falls. With io_mode=1, host_req is ignored.
- R10: mac_en is high exactly when the state is not RESET.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| start_cmd | input | 1 | Start command; leaves RESET |
| stop_cmd | input | 1 | Stop command; enters RESET |
| reg_reset | input | 1 | Register-triggered reset |
| fatal_err | input | 1 | FIFO underflow/overflow or receive ring overflow |
| io_mode | input | 1 | 1 = I/O mode, 0 = shared-memory mode |
| burst_sel | input | 2 | Burst length code (2/4/8/12 bytes) |
| fifo_req | input | 1 | FIFO requests a local DMA burst |
| fifo_level | input | LVL_W | Current FIFO fill level |
| fifo_thresh | input | LVL_W | FIFO threshold for burst re-arm |
| rdma_req | input | 1 | Remote DMA request |
| host_req | input | 1 | Host CPU direct access request |
| state | output | 2 | 0 RESET, 1 IDLE, 2 MASTER, 3 SLAVE |
| mac_en | output | 1 | Receiver/transmitter enable |
| bus_grant | output | 1 | Block drives the memory bus; one byte per cycle |
| host_grant | output | 1 | Memory bus handed to the host CPU |
| burst_src | output | 1 | Owner of the current burst: 0 local, 1 remote |

## Verification
The assertions check, on every cycle, the following: any reset cause leads to RESET, RESET holds until start, a running burst is never cut short by another request, local requests beat remote ones in IDLE, and every completed burst lasts the length its code selects. Some behaviours show only in the bench's scenarios. These are the threshold gate holding back a second burst, the remote and host requests ignored in the wrong mode, the grant dropping within the same cycle as a fatal error, and the order in which queued bursts from the two sources come out.

// File: rtl/lbus_arbiter.sv
module lbus_arbiter #(
  parameter int LVL_W = 5,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic             reg_reset,
  input  logic             fatal_err,
  input  logic             io_mode,
  input  logic [1:0]       burst_sel,
  input  logic             fifo_req,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] fifo_thresh,
  input  logic             rdma_req,
  input  logic             host_req,
  output logic [1:0]       state,
  output logic             mac_en,
  output logic             bus_grant,
  output logic             host_grant,
  output logic             burst_src
);

  localparam logic [1:0] ST_RST  = 2'd0;
  localparam logic [1:0] ST_IDLE = 2'd1;
  localparam logic [1:0] ST_MST  = 2'd2;
  localparam logic [1:0] ST_SLV  = 2'd3;

  function automatic logic [CNT_W-1:0] len_m1(input logic [1:0] code);
    case (code)
      2'd0:    len_m1 = CNT_W'(1);
      2'd1:    len_m1 = CNT_W'(3);
      2'd2:    len_m1 = CNT_W'(7);
      default: len_m1 = CNT_W'(11);
    endcase
  endfunction

  logic [1:0]       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             src_q;
  logic             gate_q;

  wire abort     = stop_cmd | reg_reset | fatal_err;
  wire local_ok  = fifo_req & (~gate_q | (fifo_level > fifo_thresh));
  wire remote_ok = rdma_req & io_mode;
  wire host_ok   = host_req & ~io_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RST;
      cnt_q  <= '0;
      src_q  <= 1'b0;
      gate_q <= 1'b0;
    end else if (abort) begin
      st_q   <= ST_RST;
      cnt_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      case (st_q)
        ST_RST: begin
          gate_q <= 1'b0;
          if (start_cmd) st_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (!fifo_req) gate_q <= 1'b0;
          if (local_ok) begin
            st_q  <= ST_MST;
            src_q <= 1'b0;
            cnt_q <= len_m1(burst_sel);
          end else if (remote_ok) begin
            st_q  <= ST_MST;
            src_q <= 1'b1;
            cnt_q <= len_m1(burst_sel);
          end else if (host_ok) begin
            st_q  <= ST_SLV;
          end
        end
        ST_MST: begin
          if (cnt_q == '0) begin
            st_q <= ST_IDLE;
            if (!src_q) gate_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          if (!host_ok) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign state      = st_q;
  assign mac_en     = st_q != ST_RST;
  assign bus_grant  = (st_q == ST_MST) & ~abort;
  assign host_grant = (st_q == ST_SLV) & ~abort;
  assign burst_src  = src_q;

  logic [CNT_W:0] chk_run;
  logic [1:0]     chk_sel;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_run <= '0;
      chk_sel <= '0;
    end else begin
      chk_run <= (st_q == ST_MST) ? chk_run + 1'b1 : '0;
      if (st_q == ST_IDLE) chk_sel <= burst_sel;
    end
  end

  assert_abort_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> st_q == ST_RST);

  assert_hold_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RST && !start_cmd) |=> st_q == ST_RST);

  assert_no_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MST && cnt_q != '0 && !abort) |=> (st_q == ST_MST && $stable(src_q)));

  assert_local_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && local_ok && !abort) |=> (bus_grant || abort) && !src_q);

  assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && $past(st_q) == ST_MST) |->
      chk_run == {1'b0, len_m1(chk_sel)} + 1'b1);

endmodule

// File: tb/test_lbus_arbiter.sv
module test_lbus_arbiter;
  localparam int LVL_W = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic start_cmd = 0, stop_cmd = 0, reg_reset = 0, fatal_err = 0;
  logic io_mode = 1;
  logic [1:0] burst_sel = 0;
  logic fifo_req = 0;
  logic [LVL_W-1:0] fifo_level = 0, fifo_thresh = 8;
  logic rdma_req = 0, host_req = 0;
  logic [1:0] state;
  logic mac_en, bus_grant, host_grant, burst_src;

  always #10 clk = ~clk;

  lbus_arbiter #(.LVL_W(LVL_W)) i_lbus_arbiter (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .reg_reset(reg_reset), .fatal_err(fatal_err), .io_mode(io_mode),
    .burst_sel(burst_sel), .fifo_req(fifo_req), .fifo_level(fifo_level),
    .fifo_thresh(fifo_thresh), .rdma_req(rdma_req), .host_req(host_req),
    .state(state), .mac_en(mac_en), .bus_grant(bus_grant),
    .host_grant(host_grant), .burst_src(burst_src));

  typedef struct packed { logic src; logic [4:0] len; } burst_t;
  burst_t exp_q[$];
  int errors = 0, checks = 0;
  bit finished = 0;

  function automatic int blen(input logic [1:0] c);
    case (c) 2'd0: return 2; 2'd1: return 4; 2'd2: return 8; default: return 12; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic src, input logic [1:0] code);
    burst_t b;
    b.src = src; b.len = 5'(blen(code));
    exp_q.push_back(b);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_grant_end();
    while (bus_grant) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: measures each burst and compares it with the scoreboard
  int run = 0;
  logic run_src = 0;
  always @(posedge clk) begin
    #5;
    if (!rst_n) run = 0;
    else if (bus_grant) begin
      run++;
      run_src = burst_src;
    end else if (run != 0) begin
      if (state == 2'd1) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected burst", run, 0);
        else begin
          burst_t e;
          e = exp_q.pop_front();
          chk(run == int'(e.len), "R4/R6/R8 burst length", run, int'(e.len));
          chk(run_src == e.src, "R6/R7 burst source", int'(run_src), int'(e.src));
        end
      end
      run = 0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
    end
  end

  initial begin
    bit ok;
    tick(2);
    // R1 reset state
    chk(state == 0 && !bus_grant && !host_grant && !mac_en, "R1 reset state", int'(state), 0);
    rst_n = 1;
    // R2 requests ignored before start
    fifo_req = 1; fifo_level = 20; host_req = 1;
    ok = 1;
    for (int i = 0; i < 5; i++) begin tick(1); if (state != 0 || bus_grant) ok = 0; end
    chk(ok, "R2 requests ignored in reset", int'(state), 0);
    chk(!mac_en, "R10 mac_en low in reset", int'(mac_en), 0);
    fifo_req = 0; host_req = 0;
    // R3 start with stop: stop wins
    start_cmd = 1; stop_cmd = 1; tick(1);
    start_cmd = 0; stop_cmd = 0;
    chk(state == 0, "R3 stop beats start", int'(state), 0);
    start_cmd = 1; tick(1); start_cmd = 0;
    chk(state == 1 && mac_en, "R2 start to idle", int'(state), 1);
    start_cmd = 1; tick(1); start_cmd = 0;
    chk(state == 1, "R2 start in idle no effect", int'(state), 1);

    // R5 threshold gate
    io_mode = 1; burst_sel = 0; fifo_thresh = 8; fifo_level = 3; fifo_req = 1;
    push(0, 0);
    tick(1);
    chk(bus_grant && !burst_src, "R4 first local burst ungated", int'(bus_grant), 1);
    wait_grant_end();
    ok = 1;
    for (int i = 0; i < 6; i++) begin tick(1); if (bus_grant || state != 1) ok = 0; end
    chk(ok, "R5 gated below threshold", int'(bus_grant), 0);
    fifo_level = 9; push(0, 0);
    tick(1);
    chk(bus_grant, "R5 burst above threshold", int'(bus_grant), 1);
    fifo_req = 0;
    wait_grant_end(); tick(2);

    // R4 each length code
    for (int c = 1; c < 4; c++) begin
      burst_sel = 2'(c); fifo_level = 20; fifo_req = 1; push(0, 2'(c));
      tick(1); fifo_req = 0;
      wait_grant_end(); tick(2);
    end

    // R7 priority and R6 remote burst
    burst_sel = 1; fifo_req = 1; rdma_req = 1; fifo_level = 20;
    push(0, 1); push(1, 1);
    tick(1); fifo_req = 0;
    chk(bus_grant && !burst_src, "R7 local first", int'(burst_src), 0);
    wait_grant_end();
    while (!bus_grant) tick(1);
    rdma_req = 0;
    wait_grant_end(); tick(2);

    // R8 no preemption, length latched
    burst_sel = 3; fifo_req = 1; push(0, 3); push(1, 0);
    tick(1); fifo_req = 0; rdma_req = 1; burst_sel = 0;
    wait_grant_end();
    while (!bus_grant) tick(1);
    rdma_req = 0;
    wait_grant_end(); tick(2);

    // R6 remote ignored in shared mode
    io_mode = 0; rdma_req = 1;
    ok = 1;
    for (int i = 0; i < 8; i++) begin tick(1); if (bus_grant) ok = 0; end
    chk(ok, "R6 remote ignored shared mode", int'(bus_grant), 0);
    rdma_req = 0;

    // R9 host access
    host_req = 1; tick(1);
    chk(host_grant && state == 3, "R9 host grant", int'(state), 3);
    ok = 1;
    for (int i = 0; i < 5; i++) begin tick(1); if (!host_grant) ok = 0; end
    chk(ok, "R9 host grant held", int'(host_grant), 1);
    host_req = 0; tick(1);
    chk(!host_grant && state == 1, "R9 host release", int'(state), 1);
    io_mode = 1; host_req = 1;
    ok = 1;
    for (int i = 0; i < 4; i++) begin tick(1); if (host_grant) ok = 0; end
    chk(ok, "R9 host ignored in io mode", int'(host_grant), 0);
    host_req = 0;

    // R3 fatal error mid-burst
    burst_sel = 3; fifo_req = 1; tick(1); fifo_req = 0;
    tick(3);
    fatal_err = 1; #1;
    chk(!bus_grant, "R3 grant drops at once", int'(bus_grant), 0);
    tick(1); fatal_err = 0;
    chk(state == 0 && !mac_en, "R3 fatal to reset", int'(state), 0);
    start_cmd = 1; tick(1); start_cmd = 0;
    chk(state == 1, "R2 restart", int'(state), 1);

    // R3 stop from idle, reg_reset from slave
    stop_cmd = 1; tick(1); stop_cmd = 0;
    chk(state == 0, "R3 stop to reset", int'(state), 0);
    start_cmd = 1; tick(1); start_cmd = 0;
    io_mode = 0; host_req = 1; tick(1);
    chk(state == 3, "R9 slave before reg reset", int'(state), 3);
    reg_reset = 1; #1;
    chk(!host_grant, "R3 host grant drops", int'(host_grant), 0);
    tick(1); reg_reset = 0; host_req = 0;
    chk(state == 0, "R3 reg reset to reset", int'(state), 0);

    // R1 hard reset mid-burst
    start_cmd = 1; tick(1); start_cmd = 0;
    io_mode = 1; burst_sel = 2; fifo_req = 1; fifo_level = 20; tick(1); fifo_req = 0;
    tick(2);
    rst_n = 0; #1;
    chk(state == 0 && !bus_grant && !mac_en, "R1 async hard reset", int'(state), 0);
    tick(2); rst_n = 1; tick(2);
    chk(state == 0, "R2 stays reset after hard reset", int'(state), 0);

    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    report();
  end
endmodule